// File: doc/BRIEF.md
# Framed Byte-Stream Receiver with CRC Check

This block turns a raw byte stream, as delivered one byte per strobe by a serial shift-register link, into framed packets. It discards bytes until it finds a two-byte start marker, then reads a sequence number, a length byte, that many payload bytes and a 16-bit CRC. Payload bytes leave on a streaming output as they arrive, with first-beat and last-beat flags. The block does not hold a whole frame before it forwards the bytes.

Once the CRC bytes have arrived, the block pulses either a good-frame or a CRC-error flag. For good frames it also reports how many sequence numbers were skipped since the previous good frame. A run of consecutive filler bytes forces the parser back to the marker hunt, whatever state it is in. The sender uses this to recover after it has lost framing.

Top module: `pkt_frame_rx`

## Requirements
- R1: Before a frame starts, every byte is dropped until the byte 0xAA is accepted and is directly followed by the byte 0x55. Dropped bytes produce no payload beat and no status pulse.
- R2: If 0xAA is followed by any byte other than 0x55, that byte is tested again as a possible first marker byte. So the stream 0xAA 0xAA 0x55 starts a frame.
- R3: After the marker the frame carries a sequence byte, a length byte L (0..255), L payload bytes, and then the CRC high byte followed by the CRC low byte. Each payload byte appears on `pl_data_o` with `pl_vld_o` high in the cycle after it is accepted. `pl_sof_o` marks the first beat and `pl_eof_o` marks the last.
- R4: A frame with L = 0 produces no payload beats but still produces a status pulse.
- R5: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR. It covers the marker, sequence, length and payload bytes. When it matches, `frame_ok_o` pulses for one cycle, in the cycle after the CRC low byte is accepted.
- R6: When the CRC does not match, `crc_err_o` pulses in the same cycle position instead. `frame_ok_o` and `drop_o` stay low, and the frame leaves the sequence reference unchanged.
- R7: For a good frame that has a previous good frame as reference, `drop_o` pulses together with `frame_ok_o` when the value G = (seq - previous_seq - 1) mod 256 is not zero. `drop_cnt_o` carries G in that cycle and is 0 otherwise. Sequence 255 followed by sequence 0 gives no drop.
- R8: The first good frame after reset or after a resynchronisation never reports a drop.
- R9: The tenth consecutive accepted 0xFF byte forces the marker hunt from any state. That byte produces no beat and no status pulse, and the aborted frame gets no status pulse. Any other accepted byte clears the run, so 0xFF bytes inside a payload are forwarded normally when they are fewer than ten in a row.
- R10: While reset is asserted and directly after it, all outputs are low.
- R11: A cycle with `byte_vld_i` low consumes nothing, and in the following cycle `pl_vld_o`, `frame_ok_o` and `crc_err_o` are low.
- R12: `frame_ok_o` and `crc_err_o` are never high together. `pl_sof_o` and `pl_eof_o` are high only while `pl_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Incoming byte |
| byte_vld_i | input | 1 | Byte strobe, one byte per high cycle |
| pl_data_o | output | 8 | Payload byte |
| pl_vld_o | output | 1 | Payload beat valid |
| pl_sof_o | output | 1 | First payload beat of a frame |
| pl_eof_o | output | 1 | Last payload beat of a frame |
| frame_ok_o | output | 1 | Frame passed the CRC check (one-cycle pulse) |
| crc_err_o | output | 1 | Frame failed the CRC check (one-cycle pulse) |
| drop_o | output | 1 | Skipped sequence numbers detected on a good frame |
| drop_cnt_o | output | 8 | Number of skipped sequence numbers |

## Verification
The bound checker holds on every cycle the output rules that need no knowledge of the frame: the two status pulses never coincide, a drop report only comes with a good frame, first and last flags only come with a beat, a status pulse never coincides with a beat, and an idle input cycle leaves the next cycle quiet. Everything that depends on stream content can only be shown by the bench's scenarios, which compare beats and status pulses against a scoreboard. This covers marker hunting and the re-check of a repeated 0xAA, the CRC value, the drop count arithmetic including wrap, zero-length and maximum-length frames, and a resynchronisation in mid-payload with filler runs shorter than ten.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_HUNT, ST_MARK, ST_SEQ, ST_LEN, ST_PAY, ST_CRCH, ST_CRCL
  } pfr_state_e;

  function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/pfr_crc16.sv
module pfr_crc16
  import pfr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PRE_A = 8'hAA,
  parameter logic [BYTE_W-1:0] PRE_B = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  // seed already covers both marker bytes
  localparam logic [CRC_W-1:0] SEED = crc16_step(crc16_step(CRC_INIT, PRE_A), PRE_B);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= SEED;
    else if (upd_i)  crc_q <= crc16_step(crc_q, byte_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/pfr_fill_run.sv
module pfr_fill_run
  import pfr_pkg::*;
#(
  parameter int unsigned       RUN  = 10,
  parameter logic [BYTE_W-1:0] FILL = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              fire_o
);
  localparam int unsigned CW = $clog2(RUN + 1);

  logic [CW-1:0] run_q;
  logic          is_fill;

  assign is_fill = vld_i && (byte_i == FILL);
  assign fire_o  = is_fill && (run_q == CW'(RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= '0;
    else if (vld_i) run_q <= (is_fill && !fire_o) ? run_q + 1'b1 : '0;
  end
endmodule

// File: rtl/pfr_seq_gap.sv
module pfr_seq_gap
  import pfr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] seq_i,
  output logic              gap_o,
  output logic [BYTE_W-1:0] gap_cnt_o
);
  logic              have_q;
  logic [BYTE_W-1:0] last_q;

  assign gap_cnt_o = seq_i - last_q - 1'b1;
  assign gap_o     = have_q && (gap_cnt_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (clr_i) begin
      have_q <= 1'b0;
    end else if (upd_i) begin
      have_q <= 1'b1;
      last_q <= seq_i;
    end
  end
endmodule

// File: rtl/pkt_frame_rx.sv
module pkt_frame_rx
  import pfr_pkg::*;
#(
  parameter int unsigned       RESYNC_RUN = 10,
  parameter logic [BYTE_W-1:0] FILL_BYTE  = 8'hFF,
  parameter logic [BYTE_W-1:0] MARK_HI    = 8'hAA,
  parameter logic [BYTE_W-1:0] MARK_LO    = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic [BYTE_W-1:0] pl_data_o,
  output logic              pl_vld_o,
  output logic              pl_sof_o,
  output logic              pl_eof_o,
  output logic              frame_ok_o,
  output logic              crc_err_o,
  output logic              drop_o,
  output logic [BYTE_W-1:0] drop_cnt_o
);
  pfr_state_e        state_q, state_d;
  logic [BYTE_W-1:0] rem_q, seq_q, crc_hi_q;
  logic              first_q;
  logic              fire, crc_init, crc_upd, beat, chk;
  logic              beat_g, good, bad, crc_ok;
  logic              gap;
  logic [BYTE_W-1:0] gap_cnt;
  logic [CRC_W-1:0]  crc_w;

  pfr_fill_run #(.RUN(RESYNC_RUN), .FILL(FILL_BYTE)) u_fill (
    .clk_i, .rst_ni, .vld_i(byte_vld_i), .byte_i, .fire_o(fire)
  );

  pfr_crc16 #(.PRE_A(MARK_HI), .PRE_B(MARK_LO)) u_crc (
    .clk_i, .rst_ni, .init_i(crc_init), .upd_i(crc_upd), .byte_i, .crc_o(crc_w)
  );

  pfr_seq_gap u_seq (
    .clk_i, .rst_ni, .clr_i(fire), .upd_i(good), .seq_i(seq_q),
    .gap_o(gap), .gap_cnt_o(gap_cnt)
  );

  always_comb begin
    state_d  = state_q;
    crc_init = 1'b0;
    crc_upd  = 1'b0;
    beat     = 1'b0;
    chk      = 1'b0;
    if (byte_vld_i) begin
      unique case (state_q)
        ST_HUNT: if (byte_i == MARK_HI) state_d = ST_MARK;
        ST_MARK: begin
          if (byte_i == MARK_LO) begin
            state_d  = ST_SEQ;
            crc_init = 1'b1;
          end else if (byte_i != MARK_HI) begin
            state_d = ST_HUNT;
          end
        end
        ST_SEQ: begin
          crc_upd = 1'b1;
          state_d = ST_LEN;
        end
        ST_LEN: begin
          crc_upd = 1'b1;
          state_d = (byte_i == '0) ? ST_CRCH : ST_PAY;
        end
        ST_PAY: begin
          crc_upd = 1'b1;
          beat    = 1'b1;
          if (rem_q == BYTE_W'(1)) state_d = ST_CRCH;
        end
        ST_CRCH: state_d = ST_CRCL;
        ST_CRCL: begin
          chk     = 1'b1;
          state_d = ST_HUNT;
        end
        default: state_d = ST_HUNT;
      endcase
      if (fire) state_d = ST_HUNT;
    end
  end

  assign crc_ok = ({crc_hi_q, byte_i} == crc_w);
  assign beat_g = beat && !fire;
  assign good   = chk && !fire && crc_ok;
  assign bad    = chk && !fire && !crc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      rem_q    <= '0;
      seq_q    <= '0;
      crc_hi_q <= '0;
      first_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (byte_vld_i) begin
        if (state_q == ST_SEQ)  seq_q    <= byte_i;
        if (state_q == ST_CRCH) crc_hi_q <= byte_i;
        if (state_q == ST_LEN) begin
          rem_q   <= byte_i;
          first_q <= 1'b1;
        end
        if (state_q == ST_PAY) begin
          rem_q   <= rem_q - 1'b1;
          first_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pl_data_o  <= '0;
      pl_vld_o   <= 1'b0;
      pl_sof_o   <= 1'b0;
      pl_eof_o   <= 1'b0;
      frame_ok_o <= 1'b0;
      crc_err_o  <= 1'b0;
      drop_o     <= 1'b0;
      drop_cnt_o <= '0;
    end else begin
      pl_vld_o   <= beat_g;
      pl_data_o  <= beat_g ? byte_i : '0;
      pl_sof_o   <= beat_g && first_q;
      pl_eof_o   <= beat_g && (rem_q == BYTE_W'(1));
      frame_ok_o <= good;
      crc_err_o  <= bad;
      drop_o     <= good && gap;
      drop_cnt_o <= (good && gap) ? gap_cnt : '0;
    end
  end
endmodule

// File: rtl/pkt_frame_rx_chk.sv
module pkt_frame_rx_chk
  import pfr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld_i,
  input logic              pl_vld_o,
  input logic              pl_sof_o,
  input logic              pl_eof_o,
  input logic              frame_ok_o,
  input logic              crc_err_o,
  input logic              drop_o,
  input logic [BYTE_W-1:0] drop_cnt_o
);
  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_ok_o && crc_err_o)); // R12

  AST_FLAGS_NEED_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_sof_o || pl_eof_o) |-> pl_vld_o); // R12

  AST_DROP_NEEDS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (frame_ok_o && drop_cnt_o != '0)); // R7

  AST_NO_CNT_WITHOUT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drop_o |-> (drop_cnt_o == '0)); // R7

  AST_STATUS_NOT_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok_o || crc_err_o) |-> !pl_vld_o); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> !(pl_vld_o || frame_ok_o || crc_err_o)); // R11
endmodule

bind pkt_frame_rx pkt_frame_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i),
  .pl_vld_o(pl_vld_o), .pl_sof_o(pl_sof_o), .pl_eof_o(pl_eof_o),
  .frame_ok_o(frame_ok_o), .crc_err_o(crc_err_o),
  .drop_o(drop_o), .drop_cnt_o(drop_cnt_o)
);

// File: tb/pkt_frame_rx_bench.sv
module pkt_frame_rx_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] pl_data_o, drop_cnt_o;
  logic       pl_vld_o, pl_sof_o, pl_eof_o, frame_ok_o, crc_err_o, drop_o;

  pkt_frame_rx u_pkt_frame_rx (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  logic [9:0]  beat_q[$];  // {sof, eof, data}
  logic [10:0] stat_q[$];  // {ok, err, drop, cnt}
  string       stat_req[$];
  logic [7:0]  pl[256];
  bit          have = 1'b0;
  logic [7:0]  last = '0;

  function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic logic [15:0] crc_b(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk_i);
    byte_i = b;
    byte_vld_i = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      byte_vld_i = 1'b0;
      byte_i = '0;
    end
  endtask

  task automatic send_frame(input logic [7:0] seq, input int len, input bit bad, input string req);
    logic [15:0] c;
    logic [7:0]  g;
    bit          dr;
    c = 16'hFFFF;
    c = crc_b(c, 8'hAA); c = crc_b(c, 8'h55);
    c = crc_b(c, seq);   c = crc_b(c, 8'(len));
    put(8'hAA); put(8'h55); put(seq); put(8'(len));
    for (int i = 0; i < len; i++) begin
      c = crc_b(c, pl[i]);
      beat_q.push_back({i == 0, i == len - 1, pl[i]});
      put(pl[i]);
    end
    if (bad) begin
      stat_q.push_back({1'b0, 1'b1, 1'b0, 8'h00});
    end else begin
      g  = seq - last - 8'd1;
      dr = have && (g != 8'd0);
      stat_q.push_back({1'b1, 1'b0, dr, dr ? g : 8'h00});
      have = 1'b1;
      last = seq;
    end
    stat_req.push_back(req);
    put(c[15:8]);
    put(bad ? (c[7:0] ^ 8'h01) : c[7:0]);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pl_vld_o) begin
        if (beat_q.size() == 0) chk(1'b0, "R3 unexpected beat", {pl_sof_o, pl_eof_o, pl_data_o}, 0);
        else begin
          automatic logic [9:0] e = beat_q.pop_front();
          chk({pl_sof_o, pl_eof_o, pl_data_o} == e, "R3 beat", {pl_sof_o, pl_eof_o, pl_data_o}, e);
        end
      end
      if (frame_ok_o || crc_err_o) begin
        if (stat_q.size() == 0) chk(1'b0, "R1 unexpected status", {frame_ok_o, crc_err_o}, 0);
        else begin
          automatic logic [10:0] e = stat_q.pop_front();
          automatic string rq = stat_req.pop_front();
          chk({frame_ok_o, crc_err_o, drop_o, drop_cnt_o} == e, rq,
              {frame_ok_o, crc_err_o, drop_o, drop_cnt_o}, e);
        end
      end else if (drop_o) begin
        chk(1'b0, "R7 drop without status", drop_cnt_o, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    chk({pl_vld_o, pl_sof_o, pl_eof_o, frame_ok_o, crc_err_o, drop_o, drop_cnt_o, pl_data_o} == 0,
        "R10 outputs in reset", {pl_vld_o, frame_ok_o, crc_err_o, drop_o}, 0);
    rst_ni = 1'b1;
    idle(2);
    chk({pl_vld_o, frame_ok_o, crc_err_o, drop_o, drop_cnt_o} == 0, "R10 after reset",
        {pl_vld_o, frame_ok_o, crc_err_o, drop_o}, 0);

    // R1: garbage, including a lone 0x55, before the marker
    put(8'h12); put(8'h55); put(8'h34);
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
    send_frame(8'd5, 3, 1'b0, "R1 R5 first frame");
    idle(3);
    // R2: 0xAA 0xAA 0x55 and 0xAA 0x13 then a frame
    put(8'hAA);
    pl[0] = 8'h5A;
    send_frame(8'd6, 1, 1'b0, "R2 repeated first marker byte");
    put(8'hAA); put(8'h13);
    pl[0] = 8'hA5; pl[1] = 8'h00;
    send_frame(8'd7, 2, 1'b0, "R2 broken marker");
    idle(2);
    // R7: gap of two
    pl[0] = 8'h01; pl[1] = 8'h02;
    send_frame(8'd10, 2, 1'b0, "R7 gap of two");
    // R6: bad CRC, reference stays at 10
    send_frame(8'd11, 2, 1'b1, "R6 crc mismatch");
    // R4: zero length, gap 1 relative to 10
    send_frame(8'd12, 0, 1'b0, "R4 zero length");
    idle(4);
    chk(beat_q.size() == 0 && stat_q.size() == 0, "R4 queues drained", beat_q.size(), 0);
    // R9: nine fillers do not resync; fillers in payload broken by a zero
    for (int i = 0; i < 9; i++) put(8'hFF);
    pl[0] = 8'h44;
    send_frame(8'd13, 1, 1'b0, "R9 nine fillers harmless");
    for (int i = 0; i < 11; i++) pl[i] = (i == 5) ? 8'h00 : 8'hFF;
    send_frame(8'd14, 11, 1'b0, "R9 filler runs in payload");
    idle(3);
    // R9: resync mid payload
    put(8'hAA); put(8'h55); put(8'h30); put(8'd20);
    for (int i = 0; i < 3; i++) begin
      beat_q.push_back({i == 0, 1'b0, 8'(8'h70 + i)});
      put(8'(8'h70 + i));
    end
    for (int i = 0; i < 9; i++) begin
      beat_q.push_back({1'b0, 1'b0, 8'hFF});
      put(8'hFF);
    end
    put(8'hFF);
    have = 1'b0;
    idle(4);
    chk(beat_q.size() == 0 && stat_q.size() == 0, "R9 resync no status or tenth beat",
        beat_q.size() + stat_q.size(), 0);
    // R8: first frame after resync reports no gap
    pl[0] = 8'hC3; pl[1] = 8'h3C;
    send_frame(8'd50, 2, 1'b0, "R8 first after resync");
    send_frame(8'd51, 2, 1'b0, "R7 consecutive");
    send_frame(8'd255, 2, 1'b0, "R7 large gap");
    send_frame(8'd0, 2, 1'b0, "R7 wrap no gap");
    // R3: maximum length
    for (int i = 0; i < 255; i++) pl[i] = 8'(i * 7 + 3);
    send_frame(8'd1, 255, 1'b0, "R3 max length");
    idle(6);
    chk(beat_q.size() == 0, "R3 all beats seen", beat_q.size(), 0);
    chk(stat_q.size() == 0, "R5 all status seen", stat_q.size(), 0);
    chk({pl_vld_o, frame_ok_o, crc_err_o, drop_o} == 0, "R11 quiet when idle",
        {pl_vld_o, frame_ok_o, crc_err_o, drop_o}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule